// File: doc/BRIEF.md
# Complex Sliding Correlator

This block correlates an analytic baseband stream against a short stored reference code. Each cycle in which `sample_valid` is high it accepts one 10-bit two's-complement real sample and the matching quadrature sample. The quadrature sample is produced upstream by a 129-tap Hilbert-transform filter and arrives undelayed. Inside the block the real stream passes through a fixed alignment delay of `ALIGN` samples, 64 by default, so that it lines up with the filter's group delay. The aligned real stream is the real part and the quadrature stream is the imaginary part. Both are held in windows of `WIN` samples.

The reference is a vector of `WIN` binary chips, each standing for +1 or -1, and is written one chip at a time through a small write port. Every tap therefore adds or subtracts its sample, and no multiplier is needed. For every accepted sample, once the pipeline has filled, the block registers a 32-bit real and a 32-bit imaginary correlation value and pulses `corr_valid`. A downstream processor reads each value in 16-bit halves and performs the magnitude and peak search.

Top module: `corr_sliding_top`

## Requirements
- R1: While `rst_n` is low and after reset, `corr_valid` is 0, `corr_re` and `corr_im` are 0, the windows and the alignment delay hold zeros, and every chip is +1.
- R2: `corr_valid` is high in the cycle after an accepted sample if and only if at least `ALIGN+WIN` samples, counting that one, have been accepted since reset. At the defaults this is 128.
- R3: On a result, `corr_im` equals the sum over k = 0..WIN-1 of s[k]·q[n-k]. Here q[n] is the newest quadrature sample, and chip index 0 pairs with the newest sample.
- R4: On a result, `corr_re` equals the sum over k = 0..WIN-1 of s[k]·r[n-ALIGN-k], where r[n] is the newest real sample.
- R5: In a cycle with `sample_valid` low, the windows do not move. In the cycle after it, `corr_re` and `corr_im` keep their values and `corr_valid` is 0. A gap in the input therefore leaves the results unchanged.
- R6: When `ref_we` is high, `ref_chip` is stored at chip index `ref_addr`. A stored value of 0 means s = +1 and 1 means s = -1. A write in the same cycle as an accepted sample takes effect from the next sample.
- R7: The sums are sign-extended to 32 bits without saturation. With every sample at -512, every chip at -1 gives +32768 and every chip at +1 gives -32768 (0xFFFF8000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Accept one sample pair this cycle |
| sample_re | input | 10 | Real input sample, two's complement |
| sample_im | input | 10 | Quadrature input sample from the Hilbert filter, two's complement |
| ref_we | input | 1 | Write one reference chip |
| ref_addr | input | 6 | Chip index to write (0 pairs with the newest sample) |
| ref_chip | input | 1 | Chip value: 0 for +1, 1 for -1 |
| corr_valid | output | 1 | One-cycle result strobe |
| corr_re | output | 32 | Real part of the correlation, two's complement |
| corr_im | output | 32 | Imaginary part of the correlation, two's complement |

## Verification
Pseudo-random streams under an irregular chip code expose any error in summation or sign. A sparse impulse stream shows whether each chip pairs with the right tap and whether the real branch lags by exactly `ALIGN` samples. Constant full-scale streams under all-plus and all-minus codes reach both ends of the range, which catches truncation or saturation. Alternating-sign samples against an alternating code separate a correct tap ordering from a reversed one. Gaps in the input, a chip write in the same cycle as a sample, and a reset in mid-stream followed by exactly `ALIGN+WIN` samples check the hold behaviour, the write timing and the fill boundary.

// File: rtl/corr_pkg.sv
package corr_pkg;

    // Encoding of one reference chip as stored in the chip bank.
    typedef enum logic {
        CHIP_PLUS  = 1'b0,
        CHIP_MINUS = 1'b1
    } chip_e;

endpackage

// File: rtl/corr_delay.sv
// Fixed-length sample delay. When shift_en is high, dout carries the sample
// that entered DEPTH accepted samples earlier.
module corr_delay #(
    parameter int DEPTH = 64,
    parameter int W     = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    logic signed [W-1:0] stage_d [DEPTH];
    logic signed [W-1:0] stage_q [DEPTH];

    assign dout = stage_q[DEPTH-1];

    always_comb begin
        stage_d = stage_q;
        if (shift_en) begin
            stage_d[0] = din;
            for (int k = 1; k < DEPTH; k++) begin
                stage_d[k] = stage_q[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                stage_q[k] <= '0;
            end
        end else begin
            stage_q <= stage_d;
        end
    end
endmodule

// File: rtl/corr_tapline.sv
// Correlation window. taps_d is the window as it will be after this cycle
// (index 0 newest), so the sum can include the incoming sample.
module corr_tapline #(
    parameter int DEPTH = 64,
    parameter int W     = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] taps_d [DEPTH]
);
    logic signed [W-1:0] taps_q [DEPTH];

    always_comb begin
        taps_d = taps_q;
        if (shift_en) begin
            taps_d[0] = din;
            for (int k = 1; k < DEPTH; k++) begin
                taps_d[k] = taps_q[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                taps_q[k] <= '0;
            end
        end else begin
            taps_q <= taps_d;
        end
    end
endmodule

// File: rtl/corr_chip_bank.sv
// Reference chip store, one bit per tap, written one chip per cycle.
module corr_chip_bank #(
    parameter int WIN = 64,
    parameter int AW  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic           chip_in,
    output logic [WIN-1:0] chips_q
);
    logic [WIN-1:0] chips_d;

    always_comb begin
        chips_d = chips_q;
        if (we && (int'(addr) < WIN)) begin
            chips_d[addr] = chip_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chips_q <= {WIN{corr_pkg::CHIP_PLUS}};
        end else begin
            chips_q <= chips_d;
        end
    end
endmodule

// File: rtl/corr_signed_sum.sv
// Sign-select every tap by its chip, then add through a balanced binary tree.
module corr_signed_sum #(
    parameter int WIN = 64,
    parameter int W   = 10,
    parameter int OW  = 32
) (
    input  logic signed [W-1:0]  taps [WIN],
    input  logic [WIN-1:0]       chips,
    output logic signed [OW-1:0] sum
);
    import corr_pkg::*;

    localparam int LVL   = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int LEAVES = 1 << LVL;
    localparam int NODES  = 2 * LEAVES - 1;

    // Heap layout: node i has children 2i+1 and 2i+2; leaves start at LEAVES-1.
    logic signed [OW-1:0] node [NODES];

    generate
        for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
            if (i < WIN) begin : g_tap
                logic signed [OW-1:0] ext;
                assign ext = {{(OW-W){taps[i][W-1]}}, taps[i]};
                assign node[LEAVES-1+i] =
                    (chip_e'(chips[i]) == CHIP_MINUS) ? -ext : ext;
            end else begin : g_pad
                assign node[LEAVES-1+i] = '0;
            end
        end
        for (genvar i = 0; i < LEAVES - 1; i++) begin : g_add
            assign node[i] = node[2*i+1] + node[2*i+2];
        end
    endgenerate

    assign sum = node[0];
endmodule

// File: rtl/corr_sliding_top.sv
// Complex sliding correlator: aligned real branch plus quadrature branch,
// each summed against a shared +/-1 chip code.
module corr_sliding_top #(
    parameter int WIN   = 64,
    parameter int ALIGN = 64,
    parameter int SW    = 10,
    parameter int OW    = 32,
    localparam int AW   = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_valid,
    input  logic signed [SW-1:0] sample_re,
    input  logic signed [SW-1:0] sample_im,
    input  logic                 ref_we,
    input  logic [AW-1:0]        ref_addr,
    input  logic                 ref_chip,
    output logic                 corr_valid,
    output logic [OW-1:0]        corr_re,
    output logic [OW-1:0]        corr_im
);
    localparam int FILL = ALIGN + WIN;
    localparam int CW   = $clog2(FILL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          valid;
        logic [OW-1:0] re;
        logic [OW-1:0] im;
    } corr_state_t;

    corr_state_t st_d, st_q;

    logic signed [SW-1:0] re_aligned;
    logic signed [SW-1:0] win_re_d [WIN];
    logic signed [SW-1:0] win_im_d [WIN];
    logic [WIN-1:0]       chips_q;
    logic signed [OW-1:0] sum_re;
    logic signed [OW-1:0] sum_im;

    corr_delay #(.DEPTH(ALIGN), .W(SW)) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample_valid),
        .din      (sample_re),
        .dout     (re_aligned)
    );

    corr_tapline #(.DEPTH(WIN), .W(SW)) u_win_re (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample_valid),
        .din      (re_aligned),
        .taps_d   (win_re_d)
    );

    corr_tapline #(.DEPTH(WIN), .W(SW)) u_win_im (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample_valid),
        .din      (sample_im),
        .taps_d   (win_im_d)
    );

    corr_chip_bank #(.WIN(WIN), .AW(AW)) u_chips (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ref_we),
        .addr    (ref_addr),
        .chip_in (ref_chip),
        .chips_q (chips_q)
    );

    corr_signed_sum #(.WIN(WIN), .W(SW), .OW(OW)) u_sum_re (
        .taps  (win_re_d),
        .chips (chips_q),
        .sum   (sum_re)
    );

    corr_signed_sum #(.WIN(WIN), .W(SW), .OW(OW)) u_sum_im (
        .taps  (win_im_d),
        .chips (chips_q),
        .sum   (sum_im)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (sample_valid) begin
            if (st_q.cnt < CW'(FILL)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.cnt >= CW'(FILL - 1)) begin
                st_d.valid = 1'b1;
                st_d.re    = sum_re;
                st_d.im    = sum_im;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign corr_valid = st_q.valid;
    assign corr_re    = st_q.re;
    assign corr_im    = st_q.im;
endmodule

// File: rtl/corr_checker.sv
module corr_checker #(
    parameter int WIN   = 64,
    parameter int ALIGN = 64,
    parameter int SW    = 10,
    parameter int OW    = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sample_valid,
    input logic          corr_valid,
    input logic [OW-1:0] corr_re,
    input logic [OW-1:0] corr_im
);
    localparam int FILL = ALIGN + WIN;
    localparam longint BOUND = longint'(WIN) * (longint'(1) << (SW - 1));

    int acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= 0;
        end else if (sample_valid && acc_q < FILL) begin
            acc_q <= acc_q + 1;
        end
    end

    // R2: a result only follows an accepted sample
    a_r2_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> $past(sample_valid));

    // R2: no result before the pipeline has filled
    a_r2_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> (acc_q >= FILL));

    // R2: every accepted sample after filling produces a result
    a_r2_when_filled: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && acc_q >= FILL - 1) |=> corr_valid);

    // R5: an idle cycle leaves the results untouched
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(corr_re) && $stable(corr_im) && !corr_valid));

    // R7: the imaginary sum stays inside the reachable range
    a_r7_im_range: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> (longint'($signed(corr_im)) <= BOUND &&
                        longint'($signed(corr_im)) >= -BOUND));

    // R7: the real sum stays inside the reachable range
    a_r7_re_range: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> (longint'($signed(corr_re)) <= BOUND &&
                        longint'($signed(corr_re)) >= -BOUND));
endmodule

bind corr_sliding_top corr_checker #(
    .WIN(WIN), .ALIGN(ALIGN), .SW(SW), .OW(OW)
) u_corr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .corr_valid   (corr_valid),
    .corr_re      (corr_re),
    .corr_im      (corr_im)
);

// File: tb/tb_corr_sliding_top.sv
module tb_corr_sliding_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIN   = 64;
    localparam int ALIGN = 64;
    localparam int SW    = 10;
    localparam int OW    = 32;
    localparam int AW    = 6;
    localparam int FILL  = ALIGN + WIN;
    localparam int HMAX  = 4096;
    localparam int NSCEN = 7;
    localparam int NSAMP = 140;

    // Scenario table: sample pattern mode and chip code mode.
    // sample modes: 0 random, 1 all -512, 2 all +511, 3 sparse impulses, 4 alternating
    // chip modes:   0 all +1, 1 all -1, 2 alternating, 3 irregular, 4 single -1 at index 0
    localparam int SCEN_SAMP [NSCEN] = '{0, 1, 1, 2, 3, 4, 0};
    localparam int SCEN_CHIP [NSCEN] = '{3, 1, 0, 3, 2, 2, 4};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sample_valid = 1'b0;
    logic signed [SW-1:0] sample_re = '0;
    logic signed [SW-1:0] sample_im = '0;
    logic                 ref_we = 1'b0;
    logic [AW-1:0]        ref_addr = '0;
    logic                 ref_chip = 1'b0;
    logic                 corr_valid;
    logic [OW-1:0]        corr_re;
    logic [OW-1:0]        corr_im;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    int  hre [HMAX];
    int  him [HMAX];
    int  nacc = 0;
    bit  mchip [WIN];
    logic [15:0] lf = 16'hACE1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    corr_sliding_top #(.WIN(WIN), .ALIGN(ALIGN), .SW(SW), .OW(OW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_re    (sample_re),
        .sample_im    (sample_im),
        .ref_we       (ref_we),
        .ref_addr     (ref_addr),
        .ref_chip     (ref_chip),
        .corr_valid   (corr_valid),
        .corr_re      (corr_re),
        .corr_im      (corr_im)
    );

    function automatic int rnd10();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return int'($signed(lf[9:0]));
    endfunction

    function automatic bit chip_of(int mode, int k);
        case (mode)
            0: return 1'b0;
            1: return 1'b1;
            2: return bit'(k % 2);
            3: return ((k * 7 + 3) % 5) < 2;
            default: return k == 0;
        endcase
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_chips(int mode);
        for (int k = 0; k < WIN; k++) begin
            ref_we   = 1'b1;
            ref_addr = AW'(k);
            ref_chip = chip_of(mode, k);
            mchip[k] = chip_of(mode, k);
            @(negedge clk);
        end
        ref_we = 1'b0;
    endtask

    // Drive one sample (optionally with a chip write), then check the result.
    task automatic push(int re, int im, string tag, bit wr, int waddr, bit wchip);
        longint exp_re = 0;
        longint exp_im = 0;
        bit     exp_v;
        sample_valid = 1'b1;
        sample_re    = SW'(re);
        sample_im    = SW'(im);
        ref_we       = wr;
        ref_addr     = AW'(waddr);
        ref_chip     = wchip;
        hre[nacc] = re;
        him[nacc] = im;
        for (int k = 0; k < WIN; k++) begin
            int s = mchip[k] ? -1 : 1;
            if (nacc - k >= 0)         exp_im += s * him[nacc - k];
            if (nacc - ALIGN - k >= 0) exp_re += s * hre[nacc - ALIGN - k];
        end
        exp_v = (nacc + 1) >= FILL;
        if (wr) mchip[waddr] = wchip;
        nacc++;
        @(negedge clk);
        sample_valid = 1'b0;
        ref_we       = 1'b0;
        chk(corr_valid == exp_v, "R2 valid", longint'(corr_valid), longint'(exp_v));
        if (exp_v) begin
            chk(longint'($signed(corr_re)) == exp_re, {tag, " R4 real"},
                longint'($signed(corr_re)), exp_re);
            chk(longint'($signed(corr_im)) == exp_im, {tag, " R3 imag"},
                longint'($signed(corr_im)), exp_im);
        end
    endtask

    // R5: one idle cycle must leave every output as it was
    task automatic idle_check();
        logic [OW-1:0] pre_re = corr_re;
        logic [OW-1:0] pre_im = corr_im;
        @(negedge clk);
        chk(corr_valid == 1'b0, "R5 valid idle", longint'(corr_valid), 0);
        chk(corr_re == pre_re && corr_im == pre_im, "R5 hold",
            longint'($signed(corr_im)), longint'($signed(pre_im)));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        for (int k = 0; k < WIN; k++) mchip[k] = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state under reset
        chk(corr_valid == 1'b0, "R1 valid", longint'(corr_valid), 0);
        chk(corr_re == '0, "R1 re", longint'($signed(corr_re)), 0);
        chk(corr_im == '0, "R1 im", longint'($signed(corr_im)), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int sc = 0; sc < NSCEN; sc++) begin
            string tag = (SCEN_SAMP[sc] == 1 || SCEN_SAMP[sc] == 2) ? "R7" : "main";
            load_chips(SCEN_CHIP[sc]);
            for (int i = 0; i < NSAMP; i++) begin
                int re;
                int im;
                case (SCEN_SAMP[sc])
                    0: begin re = rnd10(); im = rnd10(); end
                    1: begin re = -512; im = -512; end
                    2: begin re = 511; im = 511; end
                    3: begin re = (i % 37 == 0) ? 300 : 0; im = (i % 23 == 5) ? -200 : 0; end
                    default: begin re = (i % 2 == 1) ? 511 : -512; im = -re - 1; end
                endcase
                push(re, im, tag, 1'b0, 0, 1'b0);
                if (SCEN_SAMP[sc] == 0 && i % 11 == 10) idle_check();
            end
        end

        // R7: explicit extremes after the all -512 runs above
        load_chips(1);
        for (int i = 0; i < FILL; i++) push(-512, -512, "R7", 1'b0, 0, 1'b0);
        chk($signed(corr_re) == 32768, "R7 +32768", longint'($signed(corr_re)), 32768);
        load_chips(0);
        push(-512, -512, "R7", 1'b0, 0, 1'b0);
        chk(corr_im == 32'hFFFF8000, "R7 -32768", longint'($signed(corr_im)), -32768);

        // R6: a chip write alongside a sample applies from the next sample
        push(rnd10(), 400, "R6 same-cycle", 1'b1, 0, 1'b1);
        push(rnd10(), 400, "R6 next", 1'b0, 0, 1'b0);
        push(rnd10(), rnd10(), "R6 addr", 1'b1, WIN - 1, 1'b1);
        push(rnd10(), rnd10(), "R6 addr next", 1'b0, 0, 1'b0);

        // R1/R2: reset in mid-stream, then exactly FILL samples
        rst_n = 1'b0;
        @(negedge clk);
        chk(corr_valid == 1'b0 && corr_re == '0 && corr_im == '0, "R1 mid-reset",
            longint'($signed(corr_im)), 0);
        rst_n = 1'b1;
        nacc = 0;
        for (int k = 0; k < WIN; k++) mchip[k] = 1'b0;
        @(negedge clk);
        for (int i = 0; i < FILL; i++) push(100 + i, -3 * i, "R2 fill", 1'b0, 0, 1'b0);
        idle_check();

        finish_run();
    end
endmodule